// File: doc/BRIEF.md
# Modem Line Control and Status Tracker

This block holds the modem control and modem status registers of a 16550-style serial port. Four handshake inputs (carrier detect, ring, data-set-ready and clear-to-send) each pass through a multi-flop synchronizer. The block keeps the last accepted line state and a sticky change flag for every line. It also raises a level event toward the interrupt controller whenever any change flag is set. The control register drives the data-terminal-ready, request-to-send and two general-purpose outputs. It also holds a loopback switch that feeds the control bits back into the status inputs in place of the external pins.

A small mode machine orders the block's life. `MODE_PRIME` runs after reset until the synchronizers hold valid pin values, and in this state the line state is loaded without flagging changes. It then moves to `MODE_LIVE` (external pins tracked) or `MODE_LOOP` (control bits tracked) according to the loopback bit. The transitions are: PRIME to LIVE or LOOP when the priming count expires; LIVE to LOOP when a control write sets loopback; LOOP to LIVE when a control write clears it. Software reads and writes the registers through a byte-wide port, and reading the status register acknowledges the change flags.

Top module: `modem_line_ctrl`

## Requirements
- R1: Status register bits 7..4 show carrier-detect, ring, data-set-ready and clear-to-send, in that order. A change on an external pin appears there three clock edges after it is driven, through two synchronizer flops and the line-state register.
- R2: Status bits 3, 1 and 0 flag a change in either direction of carrier-detect, data-set-ready and clear-to-send respectively. Each flag stays set until the status register is read.
- R3: Status bit 2 is set only when the ring line goes from 1 to 0. A rising ring line leaves it clear.
- R4: A read of the status register (address 1) returns the current value and clears all four change flags. A change accepted in the same cycle as the read stays flagged.
- R5: The control register sits at address 0. Only wdata bits 4..0 are stored: bit 0 data-terminal-ready, bit 1 request-to-send, bit 2 general output 1, bit 3 general output 2, bit 4 loopback. Reads return bits 7..5 as zero.
- R6: With loopback set, status bits 7..4 show control bits 3, 2, 0 and 1 (output 2 as carrier-detect, output 1 as ring, terminal-ready as data-set-ready, request-to-send as clear-to-send). Changes caused this way set the change flags by the same rules.
- R7: With loopback set, changes on the external input pins have no effect on the status register or the event.
- R8: With loopback set, the request-to-send and terminal-ready pins are held at 0. The general outputs always follow their control bits.
- R9: After reset the control register reads 0x08, and the change flags and event are 0 even when the input pins are high during and after reset.
- R10: The modem-status event output is 1 exactly when at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read acknowledges flags) |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the selected register |
| cts_pin | input | 1 | Clear-to-send input, active high |
| dsr_pin | input | 1 | Data-set-ready input, active high |
| dcd_pin | input | 1 | Carrier-detect input, active high |
| ri_pin | input | 1 | Ring input, active high |
| rts_pin | output | 1 | Request-to-send output |
| dtr_pin | output | 1 | Terminal-ready output |
| gp1_pin | output | 1 | General-purpose output 1 |
| gp2_pin | output | 1 | General-purpose output 2 |
| mdm_event | output | 1 | Modem-status event to the interrupt logic |

## Verification
The bench goes after the ring line in both directions. A design that flags every ring toggle would raise a rising-ring flag that should not be there. It also lines a pin change up with a status read in the same cycle. A design that lets the acknowledge win would lose that change, and no event would follow. The bench holds the pins high through reset. A design that skips priming would report phantom changes at start-up. Finally, it toggles external pins while in loopback and swaps the rts/dtr bit pair. A design with a wrong loopback mapping or leaky pin gating would show wrong status bits or live handshake outputs.

// File: rtl/modem_pkg.sv
package modem_pkg;
    localparam int unsigned LINES     = 4;
    localparam int unsigned CTRL_BITS = 5;

    // Status line positions within the upper nibble (bit index - 4)
    localparam int unsigned LN_CTS = 0;
    localparam int unsigned LN_DSR = 1;
    localparam int unsigned LN_RI  = 2;
    localparam int unsigned LN_DCD = 3;

    // Control register bit positions
    localparam int unsigned CB_DTR  = 0;
    localparam int unsigned CB_RTS  = 1;
    localparam int unsigned CB_GP1  = 2;
    localparam int unsigned CB_GP2  = 3;
    localparam int unsigned CB_LOOP = 4;

    localparam logic [CTRL_BITS-1:0] CTRL_RESET = 5'b01000;

    typedef enum logic [1:0] {
        MODE_PRIME = 2'd0,
        MODE_LIVE  = 2'd1,
        MODE_LOOP  = 2'd2
    } mode_e;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
    import modem_pkg::*;
#(
    parameter int unsigned PRIME_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [7:0]           wdata_i,
    output logic [CTRL_BITS-1:0] ctrl_o,
    output mode_e                mode_o
);
    localparam int unsigned CNT_W = $clog2(PRIME_CYCLES + 1);

    logic [CTRL_BITS-1:0] ctrl_q, ctrl_n;
    mode_e                mode_q, mode_n;
    logic [CNT_W-1:0]     cnt_q;
    logic                 prime_done;

    assign ctrl_n     = wr_i ? wdata_i[CTRL_BITS-1:0] : ctrl_q;
    assign prime_done = (cnt_q == CNT_W'(PRIME_CYCLES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_PRIME;
            ctrl_q <= CTRL_RESET;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_n;
            ctrl_q <= ctrl_n;
            if (mode_q == MODE_PRIME) cnt_q <= cnt_q + 1'b1;
        end
    end

    // next-state process
    always_comb begin
        mode_n = mode_q;
        unique case (mode_q)
            MODE_PRIME: if (prime_done) mode_n = ctrl_n[CB_LOOP] ? MODE_LOOP : MODE_LIVE;
            MODE_LIVE:  if (ctrl_n[CB_LOOP])  mode_n = MODE_LOOP;
            MODE_LOOP:  if (!ctrl_n[CB_LOOP]) mode_n = MODE_LIVE;
            default:    mode_n = MODE_PRIME;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign mode_o = mode_q;

    a_r5_write_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ctrl_q == $past(wdata_i[CTRL_BITS-1:0]));
    a_r6_loop_state_tracks_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_PRIME) |-> ((mode_q == MODE_LOOP) == ctrl_q[CB_LOOP]));
endmodule

// File: rtl/modem_status_track.sv
module modem_status_track
    import modem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prime_i,
    input  logic [LINES-1:0] line_i,
    input  logic             ack_i,
    output logic [7:0]       status_o,
    output logic             event_o
);
    logic [LINES-1:0] line_q, delta_q, chg, new_flag;

    assign chg = line_q ^ line_i;

    always_comb begin
        new_flag         = chg;
        new_flag[LN_RI]  = line_q[LN_RI] & ~line_i[LN_RI];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= '0;
            delta_q <= '0;
        end else begin
            line_q <= line_i;
            if (prime_i) delta_q <= '0;
            else         delta_q <= (ack_i ? '0 : delta_q) | new_flag;
        end
    end

    assign status_o = {line_q, delta_q};
    assign event_o  = |delta_q;

    a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !prime_i) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));
    a_r3_ring_trailing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[LN_RI]) |-> ($past(line_q[LN_RI]) && !line_q[LN_RI]));
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && (line_i == line_q)) |=> (delta_q == '0));
    a_r9_prime_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        prime_i |=> !event_o);
endmodule

// File: rtl/modem_line_ctrl.sv
module modem_line_ctrl
    import modem_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              cts_pin,
    input  logic              dsr_pin,
    input  logic              dcd_pin,
    input  logic              ri_pin,
    output logic              rts_pin,
    output logic              dtr_pin,
    output logic              gp1_pin,
    output logic              gp2_pin,
    output logic              mdm_event
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam int unsigned PRIME_CYCLES = SYNC_STAGES + 1;

    logic [LINES-1:0]     ext_raw, ext_sync, loop_src, line_sel;
    logic [CTRL_BITS-1:0] ctrl;
    logic [7:0]           status;
    mode_e                mode;
    logic                 loop_on;

    assign ext_raw = {dcd_pin, ri_pin, dsr_pin, cts_pin};

    modem_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_raw), .sync_o(ext_sync)
    );

    modem_ctrl_reg #(.PRIME_CYCLES(PRIME_CYCLES)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_i(reg_wr && reg_addr == A_CTRL),
        .wdata_i(reg_wdata), .ctrl_o(ctrl), .mode_o(mode)
    );

    assign loop_on = ctrl[CB_LOOP];

    always_comb begin
        loop_src         = '0;
        loop_src[LN_DCD] = ctrl[CB_GP2];
        loop_src[LN_RI]  = ctrl[CB_GP1];
        loop_src[LN_DSR] = ctrl[CB_DTR];
        loop_src[LN_CTS] = ctrl[CB_RTS];
    end

    assign line_sel = loop_on ? loop_src : ext_sync;

    modem_status_track i_stat (
        .clk(clk), .rst_n(rst_n),
        .prime_i(mode == MODE_PRIME),
        .line_i(line_sel),
        .ack_i(reg_rd && reg_addr == A_STAT),
        .status_o(status), .event_o(mdm_event)
    );

    // output process
    always_comb begin
        rts_pin = ctrl[CB_RTS] & ~loop_on;
        dtr_pin = ctrl[CB_DTR] & ~loop_on;
        gp1_pin = ctrl[CB_GP1];
        gp2_pin = ctrl[CB_GP2];
        reg_rdata = (reg_addr == A_CTRL) ? {{(8-CTRL_BITS){1'b0}}, ctrl} : status;
    end

    a_r8_loop_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOOP) |-> (!rts_pin && !dtr_pin));
    a_r10_event_matches_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STAT) |-> (mdm_event == (reg_rdata[3:0] != 4'h0)));
    a_r7_loop_ignores_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_on && $past(loop_on) && $stable(ctrl)) |=> $stable(status[7:4]));
endmodule

// File: tb/test_modem_line_ctrl.sv
module test_modem_line_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [0:0] reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic [3:0] pins = 4'hF;  // {dcd, ri, dsr, cts}
    logic       rts_pin, dtr_pin, gp1_pin, gp2_pin, mdm_event;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    logic [3:0] m_line, m_delta;
    logic [4:0] m_ctrl;

    always #4 clk = ~clk;

    modem_line_ctrl i_modem_line_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cts_pin(pins[0]), .dsr_pin(pins[1]), .dcd_pin(pins[3]), .ri_pin(pins[2]),
        .rts_pin(rts_pin), .dtr_pin(dtr_pin), .gp1_pin(gp1_pin), .gp2_pin(gp2_pin),
        .mdm_event(mdm_event)
    );

    function automatic logic [3:0] src_of(logic [4:0] c, logic [3:0] p);
        if (c[4]) return {c[3], c[2], c[0], c[1]};
        return p;
    endfunction

    function automatic logic [3:0] flags_of(logic [3:0] o, logic [3:0] n);
        logic [3:0] f;
        f = o ^ n;
        f[2] = o[2] & ~n[2];
        return f;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic model_update();
        logic [3:0] n;
        n = src_of(m_ctrl, pins);
        m_delta = m_delta | flags_of(m_line, n);
        m_line = n;
    endtask

    task automatic set_pins(logic [3:0] v);
        @(negedge clk) pins = v;
        repeat (4) @(negedge clk);
        model_update();
    endtask

    task automatic wr_ctrl(logic [7:0] d);
        @(negedge clk) begin reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = d; end
        @(negedge clk) reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        m_ctrl = d[4:0];
        model_update();
    endtask

    task automatic read_reg(logic a, output logic [7:0] d);
        @(negedge clk) begin reg_rd = 1'b1; reg_addr = a; end
        #1 d = reg_rdata;
        @(negedge clk) reg_rd = 1'b0;
    endtask

    task automatic check_outputs(string req);
        check({req, " rts"}, {7'd0, rts_pin}, {7'd0, m_ctrl[1] & ~m_ctrl[4]});
        check({req, " dtr"}, {7'd0, dtr_pin}, {7'd0, m_ctrl[0] & ~m_ctrl[4]});
        check({req, " gp"}, {6'd0, gp2_pin, gp1_pin}, {6'd0, m_ctrl[3], m_ctrl[2]});
    endtask

    task automatic check_status(string req);
        logic [7:0] d;
        check({"R10 event ", req}, {7'd0, mdm_event}, {7'd0, |m_delta});
        read_reg(1'b1, d);
        check(req, d, {m_line, m_delta});
        m_delta = 4'h0;
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        m_line = 4'hF; m_delta = 4'h0; m_ctrl = 5'h08;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R9: reset state with pins high
        read_reg(1'b0, d);
        check("R9 ctrl reset", d, 8'h08);
        check("R9 event reset", {7'd0, mdm_event}, 8'h00);
        check_status("R9 R1 status after reset");
        check_outputs("R8 reset");

        // R1 R2: clear-to-send falls, carrier falls
        set_pins(4'b0110);
        check_status("R1 R2 two lines fall");
        set_pins(4'b0111);
        check_status("R2 cts rises");

        // R3: ring rising leaves flag clear, falling sets it
        set_pins(4'b0011);
        set_pins(4'b0111);
        check_status("R3 ring rise");
        set_pins(4'b0011);
        check_status("R3 ring fall");

        // R2: sticky across several changes
        set_pins(4'b1011);
        set_pins(4'b1001);
        repeat (5) @(negedge clk);
        check_status("R2 sticky flags");

        // R4: change accepted in the read cycle stays flagged
        check_status("R4 quiet read");
        @(negedge clk) pins = pins ^ 4'b0001;
        @(negedge clk);
        @(negedge clk) begin reg_rd = 1'b1; reg_addr = 1'b1; end
        #1 d = reg_rdata;
        check("R4 read value before late change", d, {m_line, 4'h0});
        @(negedge clk) reg_rd = 1'b0;
        model_update();
        check("R4 late change kept", {7'd0, mdm_event}, 8'h01);
        check_status("R4 late change status");

        // R5: only low five bits stored
        wr_ctrl(8'hE7);
        read_reg(1'b0, d);
        check("R5 ctrl high bits dropped", d, 8'h07);
        check_outputs("R5 outputs");
        check_status("R5 status after write");

        // R6 R8: loopback mapping with rts/dtr swapped
        wr_ctrl(8'h12);
        check_outputs("R8 loop rts held");
        check_status("R6 loop rts as cts");
        wr_ctrl(8'h19);
        check_outputs("R8 loop dtr held");
        check_status("R6 loop dtr gp2");
        wr_ctrl(8'h14);
        check_status("R6 loop gp1 as ring");
        wr_ctrl(8'h10);
        check_status("R6 R3 loop ring fall");

        // R7: external pins ignored in loopback
        set_pins(~pins);
        check_status("R7 pins ignored");
        set_pins(4'b1010);
        check("R7 event quiet", {7'd0, mdm_event}, 8'h00);
        wr_ctrl(8'h08);
        check_status("R7 leaving loop");

        // random mix
        for (int k = 0; k < 120; k++) begin
            int op;
            op = int'($urandom_range(0, 2));
            if (op == 0) set_pins(4'($urandom));
            else if (op == 1) wr_ctrl(8'($urandom));
            else check_status("R1 R2 R3 R6 random");
            if (k % 7 == 0) check_outputs("R8 random");
        end
        check_status("R4 final");
        done = 1'b1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (done);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule